// File: doc/BRIEF.md
# LIN Slave Break and Sync-Field Baud Detector

This block is the front end a LIN slave uses to lock onto a master's bit rate. It watches the synchronised serial input line. While it hunts for a break, a long run of dominant (low) level that lasts at least eleven nominal bit times marks a break. On a break it sets a sticky break flag, raises an interrupt when the interrupt is enabled, and holds the byte receiver off.

After the line returns high for the break delimiter, the block stamps falling edges of the following 0x55 sync byte with a free-running cycle counter. The first stamp is the start-bit edge. The second is the fifth falling edge, which closes a span of eight bit times. The rounded eighth of that span becomes the new clock-cycles-per-bit divider. The divider is presented together with a one-cycle load strobe, and in the same cycle the receiver-enable output rises so that the next byte is taken as the identifier.

If the sync field does not finish within 64 nominal bit times of the break, the block flags a sync error and goes back to hunting for a break. A soft clear abandons any measurement and clears both flags. Byte reception itself and checksum handling belong to the neighbouring UART.

Top module: `lin_sync_detect`

## Requirements
- R1: After reset, brk_flag, irq, sync_err, rx_en and div_load are 0 and meas_div is 0.
- R2: While hunting, a synchronised line that is low for 11*nom_div consecutive clock cycles sets brk_flag and drives rx_en to 0. A low run of 11*nom_div-1 cycles sets nothing.
- R3: irq is high exactly when brk_flag and brk_ie are both 1. A one-cycle flag_clr pulse clears brk_flag.
- R4: After a break and a return of the line to high, the first falling edge and the fifth falling edge are stamped. meas_div becomes (span+4)>>3, where span is the cycle distance between the two stamps. div_load pulses for exactly one cycle, and rx_en goes to 1 in that same cycle.
- R5: meas_div changes only in a cycle where div_load is 1, and holds its value otherwise.
- R6: Falling edges that arrive while no break has been detected (for example a 0x55 byte with no preceding break) produce no div_load and leave meas_div unchanged.
- R7: If the fifth sync edge has not been seen 64*nom_div cycles after break detection, sync_err is set, no divider is loaded, rx_en stays 0 and hunting restarts. The next detected break clears sync_err.
- R8: A soft_clr pulse clears brk_flag, sync_err and rx_en and abandons any measurement in progress, so that later sync edges load nothing until a new break is detected.
- R9: A high level on the line during a low run restarts the break count, so two low runs, each shorter than 11*nom_div cycles and separated by a short high pulse, set nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Soft clear pulse: drop flags and measurement |
| rx_in | input | 1 | Serial line from the transceiver (asynchronous) |
| nom_div | input | DIV_W | Current nominal clock cycles per bit |
| brk_ie | input | 1 | Break interrupt enable |
| flag_clr | input | 1 | Clear pulse for the break flag |
| brk_flag | output | 1 | Sticky break-detected flag |
| irq | output | 1 | Break interrupt request |
| sync_err | output | 1 | Sync field timed out |
| meas_div | output | DIV_W | Measured clock cycles per bit |
| div_load | output | 1 | One-cycle strobe: meas_div is new |
| rx_en | output | 1 | Byte receiver enable |

## Verification
The bench drives low runs of exactly 11*nom_div-1 and 11*nom_div cycles. A detector with an off-by-one threshold would either miss the real break or accept the short run. Sync fields are sent at rates away from nominal, and the fifth edge is pushed late by 0 to 7 cycles. Truncating instead of rounding, or closing the span on the wrong edge, shows up as an off-by-one or scaled meas_div. Further cases cover a sync byte with no break (which must not retune the divider), a missing sync field (which must raise sync_err at the 64-bit-time limit and not earlier), a soft clear between break and sync, and a high glitch splitting a long low run.

// File: rtl/lsbd_pkg.sv
package lsbd_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_DELIM = 2'd1,
        ST_FIRST = 2'd2,
        ST_SPAN  = 2'd3
    } lsbd_state_e;

endpackage

// File: rtl/lsbd_rx_sync.sv
module lsbd_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic line_lo,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= rx_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], rx_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign line_lo = ~chain_q[STAGES-1];
    assign fall    = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/lsbd_stamp.sv
module lsbd_stamp #(
    parameter int TS_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] stamp
);
    logic [TS_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign stamp = cnt_q;
endmodule

// File: rtl/lsbd_div_calc.sv
module lsbd_div_calc #(
    parameter int DIV_W     = 12,
    parameter int TS_W      = 20,
    parameter int SYNC_BITS = 8,
    parameter bit ROUND     = 1'b1
) (
    input  logic [TS_W-1:0]  span,
    output logic [DIV_W-1:0] div
);
    localparam int SH = $clog2(SYNC_BITS);
    localparam logic [TS_W:0] HALF = (TS_W+1)'(SYNC_BITS / 2);

    logic [TS_W:0] biased;
    logic [TS_W:0] quot;

    generate
        if (ROUND) begin : g_round
            assign biased = {1'b0, span} + HALF;
        end else begin : g_trunc
            assign biased = {1'b0, span};
        end
    endgenerate

    assign quot = biased >> SH;

    always_comb begin
        if (|quot[TS_W:DIV_W]) div = '1;
        else                   div = quot[DIV_W-1:0];
    end
endmodule

// File: rtl/lsbd_ctrl.sv
module lsbd_ctrl
    import lsbd_pkg::*;
#(
    parameter int DIV_W     = 12,
    parameter int TS_W      = 20,
    parameter int SYNC_BITS = 8,
    parameter int BRK_BITS  = 11,
    parameter int TMO_SH    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             flag_clr,
    input  logic             line_lo,
    input  logic             fall,
    input  logic [TS_W-1:0]  stamp,
    input  logic [DIV_W-1:0] nom_div,
    output logic             brk_flag,
    output logic             sync_err,
    output logic             rx_en,
    output logic             div_load,
    output logic [DIV_W-1:0] meas_div
);
    localparam int BW    = DIV_W + $clog2(BRK_BITS + 1);
    localparam int TW    = DIV_W + TMO_SH + 1;
    localparam int EDGES = SYNC_BITS / 2 + 1;
    localparam int EW    = $clog2(EDGES + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    typedef struct packed {
        lsbd_state_e      st;
        logic [BW-1:0]    low_cnt;
        logic [TW-1:0]    tmo;
        logic [EW-1:0]    edges;
        logic [TS_W-1:0]  t_first;
        logic [DIV_W-1:0] meas;
        logic             flag;
        logic             err;
        logic             rx_en;
        logic             load;
    } ctrl_t;

    ctrl_t q, n;

    logic [BW-1:0]    thr_brk;
    logic [TW-1:0]    tmo_lim;
    logic [BW-1:0]    low_inc;
    logic [TW-1:0]    tmo_inc;
    logic [TS_W-1:0]  span;
    logic [DIV_W-1:0] calc_div;

    assign thr_brk = BW'(nom_div) * BW'(BRK_BITS);
    assign tmo_lim = TW'(nom_div) << TMO_SH;
    assign low_inc = (q.low_cnt == '1) ? q.low_cnt : q.low_cnt + 1'b1;
    assign tmo_inc = (q.tmo == '1) ? q.tmo : q.tmo + 1'b1;
    assign span    = stamp - q.t_first;

    lsbd_div_calc #(
        .DIV_W(DIV_W), .TS_W(TS_W), .SYNC_BITS(SYNC_BITS), .ROUND(1'b1)
    ) i_div_calc (
        .span(span),
        .div (calc_div)
    );

    always_comb begin
        n      = q;
        n.load = 1'b0;
        if (flag_clr) n.flag = 1'b0;

        unique case (q.st)
            ST_HUNT: begin
                if (line_lo) begin
                    if (thr_brk != '0 && low_inc >= thr_brk) begin
                        n.st      = ST_DELIM;
                        n.flag    = 1'b1;
                        n.err     = 1'b0;
                        n.rx_en   = 1'b0;
                        n.low_cnt = '0;
                        n.tmo     = '0;
                        n.edges   = '0;
                    end else begin
                        n.low_cnt = low_inc;
                    end
                end else begin
                    n.low_cnt = '0;
                end
            end
            ST_DELIM: begin
                n.tmo = tmo_inc;
                if (!line_lo) n.st = ST_FIRST;
            end
            ST_FIRST: begin
                n.tmo = tmo_inc;
                if (fall) begin
                    n.t_first = stamp;
                    n.edges   = EW'(1);
                    n.st      = ST_SPAN;
                end
            end
            ST_SPAN: begin
                n.tmo = tmo_inc;
                if (fall) begin
                    if (q.edges == LAST_EDGE) begin
                        n.meas    = calc_div;
                        n.load    = 1'b1;
                        n.rx_en   = 1'b1;
                        n.st      = ST_HUNT;
                        n.low_cnt = '0;
                    end else begin
                        n.edges = q.edges + 1'b1;
                    end
                end
            end
            default: n.st = ST_HUNT;
        endcase

        if (q.st != ST_HUNT && tmo_inc >= tmo_lim) begin
            n.err     = 1'b1;
            n.st      = ST_HUNT;
            n.low_cnt = '0;
            n.load    = 1'b0;
            n.meas    = q.meas;
            n.rx_en   = 1'b0;
        end

        if (soft_clr) begin
            n.st      = ST_HUNT;
            n.flag    = 1'b0;
            n.err     = 1'b0;
            n.rx_en   = 1'b0;
            n.load    = 1'b0;
            n.meas    = q.meas;
            n.low_cnt = '0;
            n.tmo     = '0;
            n.edges   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_HUNT, default: '0};
        end else begin
            q <= n;
        end
    end

    assign brk_flag = q.flag;
    assign sync_err = q.err;
    assign rx_en    = q.rx_en;
    assign div_load = q.load;
    assign meas_div = q.meas;
endmodule

// File: rtl/lin_sync_detect.sv
module lin_sync_detect #(
    parameter int DIV_W       = 12,
    parameter int TS_W        = 20,
    parameter int SYNC_BITS   = 8,
    parameter int BRK_BITS    = 11,
    parameter int TMO_SH      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             rx_in,
    input  logic [DIV_W-1:0] nom_div,
    input  logic             brk_ie,
    input  logic             flag_clr,
    output logic             brk_flag,
    output logic             irq,
    output logic             sync_err,
    output logic [DIV_W-1:0] meas_div,
    output logic             div_load,
    output logic             rx_en
);
    logic            line_lo;
    logic            fall;
    logic [TS_W-1:0] stamp;

    lsbd_rx_sync #(.STAGES(SYNC_STAGES)) i_rx_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_in  (rx_in),
        .line_lo(line_lo),
        .fall   (fall)
    );

    lsbd_stamp #(.TS_W(TS_W)) i_stamp (
        .clk  (clk),
        .rst_n(rst_n),
        .stamp(stamp)
    );

    lsbd_ctrl #(
        .DIV_W(DIV_W), .TS_W(TS_W), .SYNC_BITS(SYNC_BITS),
        .BRK_BITS(BRK_BITS), .TMO_SH(TMO_SH)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(soft_clr),
        .flag_clr(flag_clr),
        .line_lo (line_lo),
        .fall    (fall),
        .stamp   (stamp),
        .nom_div (nom_div),
        .brk_flag(brk_flag),
        .sync_err(sync_err),
        .rx_en   (rx_en),
        .div_load(div_load),
        .meas_div(meas_div)
    );

    assign irq = brk_flag & brk_ie;
endmodule

// File: rtl/lin_sync_detect_chk.sv
module lin_sync_detect_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_clr,
    input logic             brk_flag,
    input logic             sync_err,
    input logic             rx_en,
    input logic             div_load,
    input logic [DIV_W-1:0] meas_div
);
    // R2: a fresh break always holds the receiver off
    a_r2_break_drops_rx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> !rx_en);

    // R4: a divider load releases the receiver in the same cycle
    a_r4_load_enables_rx: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |-> rx_en);

    // R4: the load strobe lasts one cycle
    a_r4_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> !div_load);

    // R5: the divider moves only with its strobe
    a_r5_meas_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(meas_div) |-> div_load);

    // R7: a sync timeout never loads and keeps the receiver off
    a_r7_err_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> (!div_load && !rx_en));

    // R8: soft clear drops every flag on the next cycle
    a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!brk_flag && !sync_err && !rx_en && !div_load));
endmodule

bind lin_sync_detect lin_sync_detect_chk #(.DIV_W(DIV_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_clr(soft_clr),
    .brk_flag(brk_flag),
    .sync_err(sync_err),
    .rx_en   (rx_en),
    .div_load(div_load),
    .meas_div(meas_div)
);

// File: tb/test_lin_sync_detect.sv
`timescale 1ns/1ps
module test_lin_sync_detect;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_clr = 1'b0;
    logic             rx_in = 1'b1;
    logic [DIV_W-1:0] nom_div = 12'd20;
    logic             brk_ie = 1'b0;
    logic             flag_clr = 1'b0;
    logic             brk_flag, irq, sync_err, div_load, rx_en;
    logic [DIV_W-1:0] meas_div;

    int checks = 0;
    int failures = 0;
    int loads = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lin_sync_detect #(.DIV_W(DIV_W)) i_lin_sync_detect (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .rx_in(rx_in),
        .nom_div(nom_div), .brk_ie(brk_ie), .flag_clr(flag_clr),
        .brk_flag(brk_flag), .irq(irq), .sync_err(sync_err),
        .meas_div(meas_div), .div_load(div_load), .rx_en(rx_en)
    );

    always @(negedge clk) if (div_load) loads++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_flag_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // 0x55 sync byte at bit period b; bit d6 (high) stretched by x cycles
    task automatic send_sync(input int b, input int x);
        drive(0, b);
        for (int i = 0; i < 8; i++) drive(((i % 2) == 0), (i == 6) ? b + x : b);
        drive(1, b);
        drive(1, 8);
    endtask

    function automatic int exp_div(input int b, input int x);
        return (8 * b + x + 4) >> 3;
    endfunction

    initial begin
        repeat (400000) @(negedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n0;
        int nom, b, x, l;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 brk_flag", brk_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 sync_err", sync_err, 0);
        chk("R1 rx_en", rx_en, 0);
        chk("R1 div_load", div_load, 0);
        chk("R1 meas_div", meas_div, 0);
        rst_n = 1'b1;
        drive(1, 10);

        // R2 boundary: one cycle short of 11*20
        drive(0, 219);
        drive(1, 10);
        chk("R2 short run no flag", brk_flag, 0);
        // R2 exact threshold
        drive(0, 220);
        drive(1, 4);
        chk("R2 break flag", brk_flag, 1);
        chk("R2 rx_en off", rx_en, 0);
        chk("R3 irq gated off", irq, 0);
        brk_ie = 1'b1;
        #1;
        chk("R3 irq on", irq, 1);
        drive(1, 16);
        n0 = loads;
        send_sync(20, 0);
        chk("R4 meas nominal", meas_div, 20);
        chk("R4 one load", loads - n0, 1);
        chk("R4 rx_en on", rx_en, 1);
        pulse_flag_clr();
        chk("R3 flag cleared", brk_flag, 0);
        chk("R3 irq cleared", irq, 0);

        // R5 hold
        drive(1, 100);
        chk("R5 meas held", meas_div, 20);

        // R6 sync without break
        n0 = loads;
        send_sync(30, 0);
        chk("R6 no load", loads - n0, 0);
        chk("R6 meas unchanged", meas_div, 20);

        // R9 glitch splits low run
        drive(0, 150);
        drive(1, 3);
        drive(0, 150);
        drive(1, 10);
        chk("R9 glitch restarts count", brk_flag, 0);

        // R4 rounding corners
        drive(0, 225); drive(1, 20);
        send_sync(20, 4);
        chk("R4 round up", meas_div, 21);
        pulse_flag_clr();
        drive(0, 225); drive(1, 20);
        send_sync(20, 3);
        chk("R4 round down", meas_div, 20);
        pulse_flag_clr();

        // R7 timeout
        n0 = loads;
        drive(0, 230);
        drive(1, 1200);
        chk("R7 no error before limit", sync_err, 0);
        drive(1, 100);
        chk("R7 error at limit", sync_err, 1);
        chk("R7 rx_en off", rx_en, 0);
        chk("R7 no load", loads - n0, 0);
        drive(0, 225); drive(1, 5);
        chk("R7 error cleared by break", sync_err, 0);
        drive(1, 15);
        send_sync(20, 0);
        pulse_flag_clr();

        // R8 soft clear between break and sync
        n0 = loads;
        drive(0, 225); drive(1, 10);
        soft_clr = 1'b1; @(negedge clk); soft_clr = 1'b0;
        chk("R8 flag cleared", brk_flag, 0);
        chk("R8 rx_en off", rx_en, 0);
        send_sync(26, 0);
        chk("R8 no load after clear", loads - n0, 0);
        chk("R8 meas unchanged", meas_div, 20);

        // R4 random rates
        for (int k = 0; k < 8; k++) begin
            nom = 12 + int'($urandom % 29);
            b = nom - nom / 8 + int'($urandom % (nom / 4 + 1));
            x = int'($urandom % 8);
            l = 11 * nom + int'($urandom % 20);
            nom_div = DIV_W'(nom);
            n0 = loads;
            drive(0, l);
            drive(1, nom);
            chk("R2 random break", brk_flag, 1);
            send_sync(b, x);
            chk("R4 random meas", meas_div, exp_div(b, x));
            chk("R4 random load", loads - n0, 1);
            chk("R4 random rx_en", rx_en, 1);
            pulse_flag_clr();
            drive(1, 20);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule